// File: doc/BRIEF.md
# Instruction Fetch Queue with Discard

This block sits between an instruction fetch stage and a 32-bit instruction memory port that uses a request/grant handshake followed by an in-order response-valid strobe. Once it is given a start address, it fetches consecutive words on its own. It keeps up to two bus transactions open at once and puts each returned word into a small FIFO. The fetch stage drains that FIFO through a valid/ready pair, and each word comes with the address it was fetched from.

A branch or flush is signalled by a one-cycle pulse on `branch_i` with the new address. In that cycle the FIFO is emptied, the output is masked and no request goes out. From the next cycle, fetching restarts at the word that holds the target. Requests still open on the bus at the branch are tagged for discard. Their responses are consumed and thrown away, so no wrong-path word ever reaches the consumer.

The queue issues a request only when room exists for its response. Room means that the words already stored plus the live requests still in flight leave a free FIFO slot. Back-pressure from the consumer therefore stops issue, and responses never need to be refused.

Top module: `fetchq_top`

## Requirements
- R1: After reset, and until the first `branch_i` pulse, `mem_req_o` and `out_valid_o` stay low.
- R2: The first request after a branch carries the target address with bits [1:0] forced to 00. Each later request carries the previous granted address plus 4.
- R3: Once `mem_req_o` is high without `mem_gnt_i`, it stays high with an unchanged `mem_addr_o` in the next cycle, unless `branch_i` is high in that cycle.
- R4: At most MAX_OUT (default 2) requests are granted without a response. Requests already marked for discard count toward this limit.
- R5: A request is granted only while the stored words plus the outstanding non-discarded requests number fewer than DEPTH (default 3). With `out_ready_i` held low after a branch, exactly DEPTH requests are granted.
- R6: Words leave in request order. `out_addr_o` is the fetch address and `out_data_o` is the word returned for it. A response appears at the output no earlier than the cycle after its `mem_rvalid_i`. A `mem_rvalid_i` with nothing outstanding breaks the protocol.
- R7: During a `branch_i` cycle, `out_valid_o` is low. Every word held before the branch is dropped.
- R8: Responses to requests granted before a branch are never delivered, including a response that arrives in the branch cycle itself. The first word delivered after a branch is the target word.
- R9: `mem_req_o` is low in any cycle where `branch_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| branch_i | input | 1 | One-cycle redirect pulse; flushes and restarts fetch |
| branch_addr_i | input | 32 | Redirect target byte address |
| out_valid_o | output | 1 | A fetched word is available |
| out_ready_i | input | 1 | Consumer accepts the word |
| out_addr_o | output | 32 | Fetch address of the presented word |
| out_data_o | output | 32 | Presented instruction word |
| mem_req_o | output | 1 | Fetch request to memory |
| mem_gnt_i | input | 1 | Memory accepts the request |
| mem_addr_o | output | 32 | Word-aligned fetch address |
| mem_rvalid_i | input | 1 | Response data valid, in request order |
| mem_rdata_i | input | 32 | Response data |

## Verification
The hardest situation to create is a redirect that lands while both transactions are still open on the bus, or in the very cycle a stale response arrives. Only then can a wrong-path word slip into the queue. A memory model with a fixed six-cycle latency lets both requests get granted, and a branch is fired right after the second grant. Long random phases with varying grant patterns, latencies, consumer stalls and branch spacing make stale responses coincide with the branch cycle. A scoreboard of expected fetch addresses catches any word that leaks through.

// File: rtl/fetchq_pkg.sv
// Shared types for the fetch queue.
// Assumes a 32-bit byte-addressed instruction space with word-sized fetches.
package fetchq_pkg;

    typedef logic [31:0] word_t;

    // One buffered fetch result: where it came from and what came back.
    typedef struct packed {
        word_t addr;
        word_t data;
    } fetch_item_t;

    localparam int unsigned WORD_BYTES = 4;

    // Address of the next sequential word.
    function automatic word_t next_word(input word_t a);
        return a + word_t'(WORD_BYTES);
    endfunction

    // Force an address onto a word boundary.
    function automatic word_t word_align(input word_t a);
        return {a[31:2], 2'b00};
    endfunction

endpackage

// File: rtl/fetchq_issue.sv
// Request generator.
// Keeps the next fetch address and decides when a request may go out.
// Assumes: the caller holds the address stable until the grant, and a
// branch pulse never coincides with a grant (the request is masked then).
module fetchq_issue
    import fetchq_pkg::*;
#(
    parameter int MAX_OUT = 2,
    parameter int DEPTH   = 3,
    localparam int OUT_W  = $clog2(MAX_OUT + 1),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             branch_i,
    input  word_t            branch_addr_i,
    input  logic             gnt_i,
    input  logic [OUT_W-1:0] total_out_i,
    input  logic [OUT_W-1:0] live_out_i,
    input  logic [CNT_W-1:0] stored_i,
    output logic             req_o,
    output word_t            addr_o
);

    logic  active_q;
    word_t addr_q;
    logic  slot_free;
    logic  bus_free;

    // Track whether fetching has started and the next word address.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            active_q <= 1'b0;
            addr_q   <= '0;
        end else if (branch_i) begin
            active_q <= 1'b1;
            addr_q   <= word_align(branch_addr_i);
        end else if (req_o && gnt_i) begin
            addr_q   <= next_word(addr_q);
        end
    end

    // Credit: a free FIFO slot for the response and a free bus slot.
    always_comb begin
        slot_free = (32'(stored_i) + 32'(live_out_i)) < 32'(DEPTH);
        bus_free  = 32'(total_out_i) < 32'(MAX_OUT);
        req_o     = active_q && !branch_i && slot_free && bus_free;
        addr_o    = addr_q;
    end

    // R2: each grant moves the fetch address on by one word.
    p_addr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o && gnt_i) |=> (addr_o == $past(addr_o) + 32'd4));

endmodule

// File: rtl/fetchq_inflight.sv
// Outstanding-request tracker.
// Holds, in issue order, the address and a discard flag for each granted
// request that has not yet seen its response. A kill marks every open
// entry for discard. Assumes responses return strictly in request order.
module fetchq_inflight
    import fetchq_pkg::*;
#(
    parameter int MAX_OUT = 2,
    localparam int OUT_W  = $clog2(MAX_OUT + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    input  word_t            push_addr_i,
    input  logic             pop_i,
    input  logic             kill_i,
    output word_t            head_addr_o,
    output logic             head_live_o,
    output logic [OUT_W-1:0] total_o,
    output logic [OUT_W-1:0] live_o
);

    logic [OUT_W-1:0]   cnt_q;
    logic [OUT_W-1:0]   cnt_after_pop;
    logic [OUT_W-1:0]   cnt_d;
    logic [MAX_OUT-1:0] drop_q;
    logic [MAX_OUT-1:0] drop_d;
    word_t              addr_q [MAX_OUT];
    word_t              addr_d [MAX_OUT];

    // Next-state: shift on response, flag on kill, append on grant.
    always_comb begin
        for (int i = 0; i < MAX_OUT; i++) begin
            addr_d[i] = addr_q[i];
            drop_d[i] = drop_q[i];
        end
        if (pop_i) begin
            for (int i = 0; i < MAX_OUT - 1; i++) begin
                addr_d[i] = addr_q[i + 1];
                drop_d[i] = drop_q[i + 1];
            end
            drop_d[MAX_OUT-1] = 1'b0;
        end
        cnt_after_pop = cnt_q - OUT_W'(pop_i);
        if (kill_i) begin
            drop_d = '1;
        end
        if (push_i) begin
            for (int i = 0; i < MAX_OUT; i++) begin
                if (OUT_W'(i) == cnt_after_pop) begin
                    addr_d[i] = push_addr_i;
                    drop_d[i] = 1'b0;
                end
            end
        end
        cnt_d = cnt_after_pop + OUT_W'(push_i);
    end

    // Occupancy and discard flags.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            drop_q <= '0;
        end else begin
            cnt_q  <= cnt_d;
            drop_q <= drop_d;
        end
    end

    // Request addresses; contents only matter while counted.
    always_ff @(posedge clk_i) begin
        for (int i = 0; i < MAX_OUT; i++) begin
            addr_q[i] <= addr_d[i];
        end
    end

    // Count open entries that will still deliver.
    always_comb begin
        live_o = '0;
        for (int i = 0; i < MAX_OUT; i++) begin
            if ((OUT_W'(i) < cnt_q) && !drop_q[i]) begin
                live_o = live_o + OUT_W'(1);
            end
        end
        total_o     = cnt_q;
        head_addr_o = addr_q[0];
        head_live_o = !drop_q[0];
    end

    // R6: a response needs an open request to belong to.
    p_rsp_has_owner_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pop_i |-> (cnt_q != '0));

    // R4: a grant only lands while a tracking slot is free.
    p_push_room_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        push_i |-> (32'(cnt_q) < 32'(MAX_OUT)));

    // R8: a kill leaves no open entry marked live.
    p_kill_marks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kill_i && !push_i) |=> (live_o == '0));

endmodule

// File: rtl/fetchq_store.sv
// Word FIFO between the bus and the consumer.
// Circular buffer of DEPTH items with a synchronous clear that wins over
// push and pop. Assumes the issuer never lets a push meet a full buffer.
module fetchq_store
    import fetchq_pkg::*;
#(
    parameter int DEPTH   = 3,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             push_i,
    input  fetch_item_t      push_item_i,
    input  logic             pop_i,
    output logic             valid_o,
    output fetch_item_t      head_o,
    output logic [CNT_W-1:0] count_o
);

    fetch_item_t      mem_q [DEPTH];
    logic [PTR_W-1:0] rd_q;
    logic [PTR_W-1:0] wr_q;
    logic [CNT_W-1:0] count_q;

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Pointers and fill level; clear empties the buffer.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rd_q    <= '0;
            wr_q    <= '0;
            count_q <= '0;
        end else if (clear_i) begin
            rd_q    <= '0;
            wr_q    <= '0;
            count_q <= '0;
        end else begin
            if (push_i) wr_q <= bump(wr_q);
            if (pop_i)  rd_q <= bump(rd_q);
            count_q <= count_q + CNT_W'(push_i) - CNT_W'(pop_i);
        end
    end

    // Storage write.
    always_ff @(posedge clk_i) begin
        if (push_i && !clear_i) begin
            mem_q[wr_q] <= push_item_i;
        end
    end

    // Head presentation.
    always_comb begin
        valid_o = (count_q != '0);
        head_o  = mem_q[rd_q];
        count_o = count_q;
    end

    // R5: the buffer never receives a word it cannot hold.
    p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && !clear_i) |-> (count_q < CNT_W'(DEPTH)));

    // R6: nothing is taken from an empty buffer.
    p_no_underflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pop_i |-> (count_q != '0));

    // R7: a clear leaves the buffer empty.
    p_clear_empties_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (count_q == '0));

endmodule

// File: rtl/fetchq_top.sv
// Instruction fetch queue top.
// Issues sequential word fetches with up to MAX_OUT open transactions,
// buffers results in a DEPTH-entry FIFO and drops wrong-path responses
// after a branch. Assumes the memory grants before it answers and answers
// in request order, at least one cycle after the grant.
module fetchq_top
    import fetchq_pkg::*;
#(
    parameter int DEPTH   = 3,
    parameter int MAX_OUT = 2,
    localparam int OUT_W  = $clog2(MAX_OUT + 1),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        branch_i,
    input  logic [31:0] branch_addr_i,
    output logic        out_valid_o,
    input  logic        out_ready_i,
    output logic [31:0] out_addr_o,
    output logic [31:0] out_data_o,
    output logic        mem_req_o,
    input  logic        mem_gnt_i,
    output logic [31:0] mem_addr_o,
    input  logic        mem_rvalid_i,
    input  logic [31:0] mem_rdata_i
);

    logic             grant;
    logic [OUT_W-1:0] total_out;
    logic [OUT_W-1:0] live_out;
    logic [CNT_W-1:0] stored;
    word_t            head_addr;
    logic             head_live;
    logic             fifo_push;
    logic             fifo_pop;
    logic             fifo_valid;
    fetch_item_t      fifo_head;
    fetch_item_t      rsp_item;

    // Join the handshakes between the parts.
    always_comb begin
        grant          = mem_req_o && mem_gnt_i;
        fifo_push      = mem_rvalid_i && head_live && !branch_i;
        rsp_item.addr  = head_addr;
        rsp_item.data  = mem_rdata_i;
        out_valid_o    = fifo_valid && !branch_i;
        fifo_pop       = out_valid_o && out_ready_i;
        out_addr_o     = fifo_head.addr;
        out_data_o     = fifo_head.data;
    end

    fetchq_issue #(
        .MAX_OUT (MAX_OUT),
        .DEPTH   (DEPTH)
    ) issue_i (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .branch_i      (branch_i),
        .branch_addr_i (branch_addr_i),
        .gnt_i         (mem_gnt_i),
        .total_out_i   (total_out),
        .live_out_i    (live_out),
        .stored_i      (stored),
        .req_o         (mem_req_o),
        .addr_o        (mem_addr_o)
    );

    fetchq_inflight #(
        .MAX_OUT (MAX_OUT)
    ) inflight_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .push_i      (grant),
        .push_addr_i (mem_addr_o),
        .pop_i       (mem_rvalid_i),
        .kill_i      (branch_i),
        .head_addr_o (head_addr),
        .head_live_o (head_live),
        .total_o     (total_out),
        .live_o      (live_out)
    );

    fetchq_store #(
        .DEPTH (DEPTH)
    ) store_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clear_i     (branch_i),
        .push_i      (fifo_push),
        .push_item_i (rsp_item),
        .pop_i       (fifo_pop),
        .valid_o     (fifo_valid),
        .head_o      (fifo_head),
        .count_o     (stored)
    );

    // R3: a pending request holds its address until granted or redirected.
    p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && !mem_gnt_i) |=> (branch_i || (mem_req_o && $stable(mem_addr_o))));

    // R9: no request in a redirect cycle.
    p_quiet_on_branch_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        branch_i |-> !mem_req_o);

    // R4: open transactions never exceed the limit.
    p_out_limit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        32'(total_out) <= 32'(MAX_OUT));

endmodule

// File: tb/fetchq_top_tb_top.sv
// Scoreboard bench for the fetch queue: a memory model with adjustable grant
// and latency behaviour, a consumer with adjustable stalls, and a queue of
// expected fetch addresses filled by the branch driver task.
module fetchq_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 3;
    localparam int MAX_OUT    = 2;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        branch_i = 1'b0;
    logic [31:0] branch_addr_i = '0;
    logic        out_valid_o;
    logic        out_ready_i = 1'b0;
    logic [31:0] out_addr_o;
    logic [31:0] out_data_o;
    logic        mem_req_o;
    logic        mem_gnt_i = 1'b0;
    logic [31:0] mem_addr_o;
    logic        mem_rvalid_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fetchq_top #(.DEPTH(DEPTH), .MAX_OUT(MAX_OUT)) dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .branch_i      (branch_i),
        .branch_addr_i (branch_addr_i),
        .out_valid_o   (out_valid_o),
        .out_ready_i   (out_ready_i),
        .out_addr_o    (out_addr_o),
        .out_data_o    (out_data_o),
        .mem_req_o     (mem_req_o),
        .mem_gnt_i     (mem_gnt_i),
        .mem_addr_o    (mem_addr_o),
        .mem_rvalid_i  (mem_rvalid_i),
        .mem_rdata_i   (mem_rdata_i)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Stimulus knobs.
    int gnt_mode = 0;   // 0 always, 1 alternate cycles, 2 random
    int rdy_mode = 0;   // 0 always, 1 never, 2 random
    int lat_lo = 0;
    int lat_hi = 0;
    bit br_req = 1'b0;
    logic [31:0] br_tgt = '0;

    // Model and scoreboard state.
    int          cyc = 0;
    logic [31:0] p_addr [$];
    int          p_at   [$];
    bit          p_live [$];
    logic [31:0] exp_q  [$];
    logic [31:0] exp_req = '0;
    int          live_words = 0;
    int          live_out = 0;
    int          grants_since_br = 0;
    int          delivered_since_br = 0;
    bit          got_first = 1'b0;
    logic [31:0] first_out_addr = '0;
    bit          prev_wait = 1'b0;
    logic [31:0] prev_addr = '0;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, a[31:16] ^ 16'h0F1E};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Driver: request a redirect, then load the expected word addresses.
    task automatic branch_to(input logic [31:0] a, input int n);
        br_tgt = a;
        br_req = 1'b1;
        wait (br_req == 1'b0);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back({a[31:2], 2'b00} + 32'(4 * k));
        end
    endtask

    // Memory model and monitor: drive at the falling edge, observe 1 later.
    always begin
        @(negedge clk);
        if (!rst_n) begin
            branch_i     = 1'b0;
            mem_gnt_i    = 1'b0;
            mem_rvalid_i = 1'b0;
            out_ready_i  = 1'b0;
            prev_wait    = 1'b0;
        end else begin
            cyc++;
            if (br_req) begin
                branch_i      = 1'b1;
                branch_addr_i = br_tgt;
                foreach (p_live[i]) p_live[i] = 1'b0;
                live_out           = 0;
                live_words         = 0;
                exp_q.delete();
                exp_req            = {br_tgt[31:2], 2'b00};
                grants_since_br    = 0;
                delivered_since_br = 0;
                got_first          = 1'b0;
                br_req             = 1'b0;
            end else begin
                branch_i = 1'b0;
            end
            if (p_addr.size() > 0 && p_at[0] <= cyc) begin
                mem_rvalid_i = 1'b1;
                mem_rdata_i  = mem_word(p_addr[0]);
            end else begin
                mem_rvalid_i = 1'b0;
                mem_rdata_i  = 32'hDEAD_BEEF;
            end
            case (gnt_mode)
                0:       mem_gnt_i = 1'b1;
                1:       mem_gnt_i = cyc[0];
                default: mem_gnt_i = ($urandom_range(0, 2) != 0);
            endcase
            case (rdy_mode)
                0:       out_ready_i = 1'b1;
                1:       out_ready_i = 1'b0;
                default: out_ready_i = ($urandom_range(0, 2) != 0);
            endcase

            #1;
            // R9 and R7: redirect cycle is quiet on both sides.
            if (branch_i) begin
                chk(!mem_req_o, "R9", 32'(mem_req_o), 32'd0);
                chk(!out_valid_o, "R7", 32'(out_valid_o), 32'd0);
            end
            // R3: an ungranted request is held.
            if (prev_wait && !branch_i) begin
                chk(mem_req_o && (mem_addr_o == prev_addr), "R3", mem_addr_o, prev_addr);
            end
            // R2, R4, R5 at each grant.
            if (mem_req_o && mem_gnt_i) begin
                chk(mem_addr_o == exp_req, "R2", mem_addr_o, exp_req);
                chk(p_addr.size() < MAX_OUT, "R4", 32'(p_addr.size()), 32'(MAX_OUT - 1));
                chk(live_words + live_out < DEPTH, "R5", 32'(live_words + live_out),
                    32'(DEPTH - 1));
            end
            // R6 and R8: scoreboard on delivered words.
            if (out_valid_o && out_ready_i) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6", out_addr_o, 32'hFFFF_FFFF);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(out_addr_o == e, "R6", out_addr_o, e);
                    chk(out_data_o == mem_word(e), "R6", out_data_o, mem_word(e));
                end
                if (!got_first) begin
                    got_first      = 1'b1;
                    first_out_addr = out_addr_o;
                end
            end

            // Apply this cycle's events to the model state.
            if (mem_rvalid_i) begin
                if (p_live[0]) begin
                    live_words++;
                    live_out--;
                end
                void'(p_addr.pop_front());
                void'(p_at.pop_front());
                void'(p_live.pop_front());
            end
            if (out_valid_o && out_ready_i) begin
                live_words--;
                delivered_since_br++;
            end
            if (mem_req_o && mem_gnt_i) begin
                p_addr.push_back(mem_addr_o);
                p_at.push_back(cyc + 1 + $urandom_range(lat_lo, lat_hi));
                p_live.push_back(1'b1);
                live_out++;
                exp_req = exp_req + 32'd4;
                grants_since_br++;
            end
            prev_wait = mem_req_o && !mem_gnt_i;
            prev_addr = mem_addr_o;
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // Watchdog.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        // R1: idle during and after reset until the first redirect.
        repeat (3) @(negedge clk);
        #2;
        chk(!mem_req_o && !out_valid_o, "R1", {30'd0, mem_req_o, out_valid_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            #2;
            chk(!mem_req_o && !out_valid_o, "R1", {30'd0, mem_req_o, out_valid_o}, 32'd0);
        end

        // R2, R6: streaming from an unaligned target, fast memory.
        gnt_mode = 0; rdy_mode = 0; lat_lo = 0; lat_hi = 0;
        branch_to(32'h0000_0102, 400);
        repeat (60) @(negedge clk);
        chk(delivered_since_br >= 20, "R6", 32'(delivered_since_br), 32'd20);

        // R5: consumer stalled, exactly DEPTH grants, then drain in order.
        rdy_mode = 1;
        branch_to(32'h0000_2000, 400);
        repeat (20) @(negedge clk);
        chk(grants_since_br == DEPTH, "R5", 32'(grants_since_br), 32'(DEPTH));
        chk(delivered_since_br == 0, "R5", 32'(delivered_since_br), 32'd0);
        rdy_mode = 0;
        repeat (30) @(negedge clk);
        chk(delivered_since_br >= 10, "R5", 32'(delivered_since_br), 32'd10);

        // R8, R4: redirect with two slow requests open.
        lat_lo = 6; lat_hi = 6;
        branch_to(32'h0000_0300, 400);
        while (grants_since_br < 2) @(negedge clk);
        branch_to(32'h0000_4000, 400);
        repeat (40) @(negedge clk);
        chk(got_first && first_out_addr == 32'h0000_4000, "R8", first_out_addr,
            32'h0000_4000);

        // R3: alternating grants with a random consumer.
        gnt_mode = 1; rdy_mode = 2; lat_lo = 0; lat_hi = 2;
        branch_to(32'h0000_5552, 400);
        repeat (200) @(negedge clk);
        chk(delivered_since_br > 0, "R3", 32'(delivered_since_br), 32'd1);

        // R7, R8: random grants, latencies, stalls and redirect spacing.
        gnt_mode = 2; lat_lo = 0; lat_hi = 4;
        for (int it = 0; it < 40; it++) begin
            branch_to({$urandom_range(0, 32'h0000_FFFF), 2'($urandom_range(0, 3))}, 400);
            repeat ($urandom_range(1, 120)) @(negedge clk);
        end
        repeat (40) @(negedge clk);

        summary();
        $finish;
    end

endmodule